// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block gathers eight single-cycle event pulses from a serial flash controller and turns them into one level-sensitive interrupt line. Each pulse sets a sticky bit in a raw status vector. A per-source mask decides which sticky bits may reach the interrupt line, and a write-one-to-clear register lets software retire the bits it has serviced. Software sees four views through a small register port: the mask, the clear register, the raw status and the masked (pending) status.

Masking gates only the interrupt line and the pending view. Raw bits keep latching while masked and stay set until the clear register removes them. A controller soft reset elsewhere in the chip does not touch them, so software writes all ones to the clear register after such a reset. The register port has no handshake. A write takes effect at the clock edge that samples it. Reads are combinational from the selected register.

The block has no sequencing of its own. All state is in three registers: the raw vector, the mask vector and the registered interrupt line. Each register moves from its reset value to its next value on every clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: Source positions are fixed. Bit 0 is RX full, bit 1 RX underflow, bit 2 TX overflow, bit 3 TX empty, bit 4 transfer finish, bit 5 bus error, bit 6 protocol error and bit 7 DMA done. A pulse on input bit i sets raw bit i only.
- R2: A pulse sets its raw bit at the next clock edge whether or not that source is masked.
- R3: Address 0 is the mask register, readable and writable. A mask bit of 1 blocks its source and a 0 lets it through. A written value is visible from the next cycle.
- R4: A write to address 1 (clear) clears every raw bit whose data bit is 1. Raw bits whose data bit is 0 are left unchanged.
- R5: If a source pulses in the same cycle that its bit is cleared, the raw bit stays set.
- R6: Address 3 reads the pending status, which equals raw AND NOT mask.
- R7: irq_o is the OR of all pending bits, registered once. It follows a change of the pending status one cycle later.
- R8: After power-on reset the raw bits are 0, the mask bits are all 1 and irq_o is 0.
- R9: Address 2 reads the raw status, and writes to address 2 are ignored. Address 1 reads as zero.
- R10: Raw bits fall only through a clear write. Changing the mask does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 clear, 2 raw, 3 pending |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Combinational read data of the selected register |
| irq_o | output | 1 | Level interrupt output |

## Verification
Raw, mask and pending values are due in the cycle right after the edge that samples a pulse or a write, because the read port is combinational. The interrupt line is due one cycle later than the pending status it summarises. The bench drives each stimulus for exactly one cycle. It then queues its expected read value and interrupt level for the following cycle and samples both mid-way through the low phase, well clear of the sampling edge. It checks the interrupt line in the first cycle after an unmask, where the old level is still expected, and again one cycle later.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;

    localparam int REG_ADDR_W = 2;

    // Register selector values seen on the register port
    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_MASK  = 2'd0,
        SEL_CLEAR = 2'd1,
        SEL_RAW   = 2'd2,
        SEL_PEND  = 2'd3
    } reg_sel_e;

    // Event source positions in every status vector
    typedef enum int {
        SRC_RX_FULL    = 0,
        SRC_RX_UNDER   = 1,
        SRC_TX_OVER    = 2,
        SRC_TX_EMPTY   = 3,
        SRC_XFER_DONE  = 4,
        SRC_BUS_ERR    = 5,
        SRC_PROTO_ERR  = 6,
        SRC_DMA_DONE   = 7
    } evt_src_e;

    localparam int DEFAULT_NUM_SRC = SRC_DMA_DONE + 1;

endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    // One sticky bit per source; a set in the same cycle beats a clear
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                raw_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                raw_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NUM_SRC-1:0] value_i,
    output logic [NUM_SRC-1:0] mask_o
);

    // All sources blocked out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (load_i) begin
            mask_o <= value_i;
        end
    end

endmodule

// File: rtl/irq_line_gen.sv
`timescale 1ns/1ps
module irq_line_gen #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);

    always_comb begin
        pend_o = raw_i & ~mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_o;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int NUM_SRC = DEFAULT_NUM_SRC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    evt_pulse_i,
    input  logic                  reg_wr_en_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [NUM_SRC-1:0]    reg_wdata_i,
    output logic [NUM_SRC-1:0]    reg_rdata_o,
    output logic                  irq_o
);

    reg_sel_e           sel;
    logic               mask_wr;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;

    // Write decode
    always_comb begin
        sel     = reg_sel_e'(reg_addr_i);
        mask_wr = reg_wr_en_i && (sel == SEL_MASK);
        clr_vec = (reg_wr_en_i && (sel == SEL_CLEAR)) ? reg_wdata_i : '0;
    end

    irq_src_latch #(.NUM_SRC(NUM_SRC)) latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse_i),
        .clr_i (clr_vec),
        .raw_o (raw_q)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (mask_wr),
        .value_i (reg_wdata_i),
        .mask_o  (mask_q)
    );

    irq_line_gen #(.NUM_SRC(NUM_SRC)) line_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_q),
        .mask_i (mask_q),
        .pend_o (pend),
        .irq_o  (irq_o)
    );

    // Read mux; the clear register has no storage and reads as zero
    always_comb begin
        unique case (sel)
            SEL_MASK:  reg_rdata_o = mask_q;
            SEL_CLEAR: reg_rdata_o = '0;
            SEL_RAW:   reg_rdata_o = raw_q;
            SEL_PEND:  reg_rdata_o = pend;
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_stat_chk.sv
`timescale 1ns/1ps
module irq_stat_chk
    import irq_stat_pkg::*;
#(
    parameter int NUM_SRC = DEFAULT_NUM_SRC
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SRC-1:0]    evt,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0]    wdata,
    input logic [NUM_SRC-1:0]    raw,
    input logic [NUM_SRC-1:0]    mask,
    input logic [NUM_SRC-1:0]    rdata,
    input logic                  irq
);

    logic               clr_now;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        clr_now  = wr_en && (addr == SEL_CLEAR);
        clr_bits = clr_now ? wdata : '0;
    end

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> ((raw & $past(wdata) & ~$past(evt)) == '0));

    // R10
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw) & ~raw) & ~$past(clr_bits)) == '0));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|($past(raw) & ~$past(mask)))));

    // R6
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_PEND) |-> (rdata == (raw & ~mask)));

    // R3
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == SEL_MASK)) |=> (mask == $past(wdata)));

endmodule

bind irq_status_unit irq_stat_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_pulse_i),
    .wr_en (reg_wr_en_i),
    .addr  (reg_addr_i),
    .wdata (reg_wdata_i),
    .raw   (raw_q),
    .mask  (mask_q),
    .rdata (reg_rdata_o),
    .irq   (irq_o)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;

    localparam int N = 8;
    localparam logic [1:0] A_MASK = 2'd0;
    localparam logic [1:0] A_CLR  = 2'd1;
    localparam logic [1:0] A_RAW  = 2'd2;
    localparam logic [1:0] A_PEND = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    typedef struct {
        bit           is_irq;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit #(.NUM_SRC(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_pulse_i (evt),
        .reg_wr_en_i (wr_en),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // One stimulus cycle: write and/or event pulses
    task automatic cyc(input logic w, input logic [1:0] a, input logic [N-1:0] d,
                       input logic [N-1:0] e);
        @(negedge clk);
        wr_en = w;
        addr  = a;
        wdata = d;
        evt   = e;
    endtask

    // One observation cycle: queue expected read data and irq level
    task automatic look(input logic [1:0] a, input logic [N-1:0] exp_d,
                        input logic exp_irq, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        evt   = '0;
        wdata = '0;
        addr  = a;
        it.is_irq = 1'b0; it.exp = exp_d;        it.tag = tag; sb_q.push_back(it);
        it.is_irq = 1'b1; it.exp = N'(exp_irq);  it.tag = tag; sb_q.push_back(it);
    endtask

    // Monitor: compares queued expectations mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [N-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? N'(irq) : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %h expected %h", it.tag,
                             it.is_irq ? "irq" : "rdata", act, it.exp);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        look(A_MASK, 8'hFF, 1'b0, "R8");
        look(A_RAW,  8'h00, 1'b0, "R8");
        look(A_PEND, 8'h00, 1'b0, "R8");

        // R2: masked source still latches; R6 pending stays empty
        cyc(1'b0, A_RAW, 8'h00, 8'h01);
        look(A_RAW,  8'h01, 1'b0, "R2");
        look(A_PEND, 8'h00, 1'b0, "R6");

        // R1: each source lands on its own bit
        acc = 8'h01;
        for (int i = 1; i < N; i++) begin
            cyc(1'b0, A_RAW, 8'h00, N'(1) << i);
            acc = acc | (N'(1) << i);
            look(A_RAW, acc, 1'b0, "R1");
        end

        // R4: zero clear does nothing, partial clear
        cyc(1'b1, A_CLR, 8'h00, 8'h00);
        look(A_RAW, 8'hFF, 1'b0, "R4");
        cyc(1'b1, A_CLR, 8'h0F, 8'h00);
        look(A_RAW, 8'hF0, 1'b0, "R4");

        // R9: raw is read-only, clear reads zero
        cyc(1'b1, A_RAW, 8'h00, 8'h00);
        look(A_RAW, 8'hF0, 1'b0, "R9");
        look(A_CLR, 8'h00, 1'b0, "R9");

        // R3/R7: unmask transfer finish (bit 4)
        cyc(1'b1, A_MASK, 8'hEF, 8'h00);
        look(A_PEND, 8'h10, 1'b0, "R7");
        look(A_MASK, 8'hEF, 1'b1, "R3");

        // R5: event and clear together, event wins
        cyc(1'b1, A_CLR, 8'h10, 8'h10);
        look(A_RAW, 8'hF0, 1'b1, "R5");

        // R4/R7: clear alone, irq falls one cycle later
        cyc(1'b1, A_CLR, 8'h10, 8'h00);
        look(A_RAW,  8'hE0, 1'b1, "R4");
        look(A_PEND, 8'h00, 1'b0, "R7");

        // R10: unmask all, raw unchanged, irq rises
        cyc(1'b1, A_MASK, 8'h00, 8'h00);
        look(A_RAW,  8'hE0, 1'b0, "R10");
        look(A_PEND, 8'hE0, 1'b1, "R6");

        // R4: full clear
        cyc(1'b1, A_CLR, 8'hFF, 8'h00);
        look(A_RAW,  8'h00, 1'b1, "R4");
        look(A_PEND, 8'h00, 1'b0, "R7");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule